// File: doc/BRIEF.md
# Streaming Turbo Encoder Sequencer

This block sequences a rate-1/3 parallel-concatenated convolutional encoder. It takes a frame of K bits as a serial stream, one bit per cycle, framed by `in_start`, `in_end` and `in_valid`. It stores the frame in a bit buffer. When the last bit has arrived it runs two identical 8-state recursive systematic encoders side by side. The first reads the buffer in natural order. The second reads it in the order of a quadratic permutation, Π(i) = (f1·i + f2·i²) mod K, which is generated incrementally with modular adders, so no index table is stored.

Each data cycle produces a 3-bit word made of the systematic bit and the two parity bits. Four termination words follow, which drive both encoders back to the all-zero state. `out_tail1` and `out_tail2` flag the termination words of each encoder. The block size and both permutation coefficients are captured together with the first bit of a frame. The output `out_end` marks the cycle in which a new frame may begin. The delay from the last input bit to the first output word is the same for every block size.

Top module: `turbo_frame_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it, `out_valid`, `out_start`, `out_end`, `out_tail1` and `out_tail2` are all low until a frame produces output.
- R2: A frame opens on a cycle with `in_valid` and `in_start` high while idle. `blk_size`, `coef_f1` and `coef_f2` are captured there (1 ≤ K ≤ MAX_K, f1 < K, f2 < K). Each cycle with `in_valid` high stores the next bit at positions 0..K-1, and the K-th stored bit closes the frame. Cycles with `in_valid` low are skipped.
- R3: Data word i is `out_word` = {bit[2] systematic c_i, bit[1] parity1, bit[0] parity2}. Parity1 comes from an encoder that starts at zero, with feedback polynomial 1+D²+D³ and forward polynomial 1+D+D³, fed c_0..c_{K-1}.
- R4: Parity2 comes from an identical encoder, starting at zero, fed c'_i = c_{Π(i)} with Π(i) = (f1·i + f2·i²) mod K.
- R5: Output words are valid on K+4 consecutive cycles. `out_start` is high on data word 0 only, and `out_end` is high on the fourth termination word only.
- R6: The termination words are, in order: {x_K, z_K, x_{K+1}} and {z_{K+1}, x_{K+2}, z_{K+2}} of encoder 1, then the same two words of encoder 2. Here x is the input that forces the feedback to zero and z is the resulting parity, with the element listed first in bit 2.
- R7: `out_tail1` is high on termination words 1 and 2 only, `out_tail2` on termination words 3 and 4 only, and both are low on data words.
- R8: Data word 0 appears exactly two cycles after the cycle that carried the last input bit, for every K and every pattern of `in_valid` gaps.
- R9: Inputs applied while a frame is being encoded or terminated are ignored: the output words are unchanged and no extra frame follows.
- R10: A frame whose first bit is applied in the cycle where `out_end` is high is accepted and encoded correctly.
- R11: `in_end` with `in_valid` on a bit before the K-th abandons the frame: no output is produced, and the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_bit | input | 1 | Serial input data bit |
| in_start | input | 1 | First bit of a frame |
| in_end | input | 1 | Last bit of a frame |
| in_valid | input | 1 | Input bit qualifier |
| blk_size | input | KW | Block size K, captured on start |
| coef_f1 | input | KW | Linear permutation coefficient, captured on start |
| coef_f2 | input | KW | Quadratic permutation coefficient, captured on start |
| out_word | output | 3 | {systematic, parity1, parity2} or a termination word |
| out_start | output | 1 | First data word of a frame |
| out_end | output | 1 | Last termination word; ready for a new frame |
| out_valid | output | 1 | Output word qualifier |
| out_tail1 | output | 1 | Termination word of encoder 1 |
| out_tail2 | output | 1 | Termination word of encoder 2 |

## Verification
The bench sweeps several block sizes with real coefficient pairs and with all-zero, all-one, alternating and pseudo-random data. It recomputes the permutation from the closed formula and the encoders bit by bit. An address generator whose increment step is wrong gives parity2 errors that grow along the frame. An encoder with the wrong polynomial corrupts parity from the first one bit onward. A termination computed from the state with a mistake swaps or misplaces bits in the four tail words. Gapped `in_valid` and a start applied right on `out_end` expose a latency that depends on gaps, or a busy flag that clears one cycle late. An early `in_end` and input applied during encoding expose a design that emits a stray frame.

// File: rtl/turbo_seq_pkg.sv
// Package: shared phase type for the turbo encoder sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package turbo_seq_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_FILL = 2'd1,
        PH_ENC  = 2'd2,
        PH_TAIL = 2'd3
    } phase_t;
endpackage

// File: rtl/frame_bit_store.sv
// Module: single-bit-wide frame store with one write port and two
// combinational read ports (natural and permuted order).
// Assumes addresses stay below DEPTH; the caller guarantees it.
module frame_bit_store #(
    parameter int DEPTH = 512,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wdata,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output logic          rdata_a,
    output logic          rdata_b
);
    logic [DEPTH-1:0] mem;

    // Stores one incoming bit per write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Two independent read ports.
    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/qpp_index_gen.sv
// Module: incremental quadratic permutation index generator.
// Produces P(i) = (f1*i + f2*i*i) mod K one index per step, using only
// modular additions: P(i+1) = P(i) + g(i), g(i+1) = g(i) + 2*f2.
// Assumes f1 < K and f2 < K at load; load and step are never both high.
module qpp_index_gen #(
    parameter int KW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [KW-1:0] k_in,
    input  logic [KW-1:0] f1_in,
    input  logic [KW-1:0] f2_in,
    output logic [KW-1:0] idx
);
    logic [KW-1:0] k_q, g_q, inc_q;

    // Adds two residues below m and folds once.
    function automatic logic [KW-1:0] add_mod(input logic [KW-1:0] a,
                                              input logic [KW-1:0] b,
                                              input logic [KW-1:0] m);
        logic [KW:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= {1'b0, m}) s = s - {1'b0, m};
        return s[KW-1:0];
    endfunction

    // Loads the recurrence seeds or advances the index by one position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            k_q   <= '0;
            g_q   <= '0;
            inc_q <= '0;
            idx   <= '0;
        end else if (load) begin
            k_q   <= k_in;
            g_q   <= add_mod(f1_in, f2_in, k_in);
            inc_q <= add_mod(f2_in, f2_in, k_in);
            idx   <= '0;
        end else if (step) begin
            idx <= add_mod(idx, g_q, k_q);
            g_q <= add_mod(g_q, inc_q, k_q);
        end
    end

    assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (idx < k_q && g_q < k_q));
endmodule

// File: rtl/rsc_encoder.sv
// Module: 8-state recursive systematic convolutional encoder,
// feedback 1+D^2+D^3, forward 1+D+D^3.
// Gives the parity of the current input combinationally, and the two
// termination words computed from the held state (three flushing steps
// unrolled). Assumes clear and step are never both high.
module rsc_encoder (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  logic       bit_in,
    output logic       parity,
    output logic [2:0] term_a,
    output logic [2:0] term_b
);
    logic [2:0] st;     // st[0] newest delay, st[2] oldest
    logic       fb;

    assign fb     = bit_in ^ st[1] ^ st[2];
    assign parity = fb ^ st[0] ^ st[2];

    // Termination words {x0,z0,x1} and {z1,x2,z2} from the held state.
    assign term_a = {st[1] ^ st[2], st[0] ^ st[2], st[0] ^ st[1]};
    assign term_b = {st[1], st[0], st[0]};

    // Shifts the feedback bit into the delay line.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) st <= '0;
        else if (step)       st <= {st[1], st[0], fb};
    end

    assert_clear_zeroes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (st == 3'b000));
endmodule

// File: rtl/turbo_frame_seq.sv
// Module: frame sequencer of a streaming rate-1/3 turbo encoder.
// Collects K bits, then emits K data words {c, p1, p2} and four
// termination words with per-encoder flags. Inputs are ignored while a
// frame is encoded. Assumes 1 <= K <= MAX_K and coefficients below K.
module turbo_frame_seq
    import turbo_seq_pkg::*;
#(
    parameter int MAX_K = 512,
    parameter int KW    = $clog2(MAX_K + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_bit,
    input  logic          in_start,
    input  logic          in_end,
    input  logic          in_valid,
    input  logic [KW-1:0] blk_size,
    input  logic [KW-1:0] coef_f1,
    input  logic [KW-1:0] coef_f2,
    output logic [2:0]    out_word,
    output logic          out_start,
    output logic          out_end,
    output logic          out_valid,
    output logic          out_tail1,
    output logic          out_tail2
);
    localparam int AW = $clog2(MAX_K);
    localparam int NENC = 2;

    phase_t        phase;
    logic [KW-1:0] k_q;
    logic [KW-1:0] cnt;
    logic          open_frame, take_bit, last_bit, early_end;
    logic          buf_we;
    logic [AW-1:0] buf_waddr;
    logic          rd_nat, rd_perm;
    logic [KW-1:0] perm_idx;
    logic          enc_step, enc_clear;
    logic [NENC-1:0] enc_in, enc_par;
    logic [2:0]    term_a [NENC];
    logic [2:0]    term_b [NENC];
    logic [2:0]    tail_word;

    // Frame acceptance decode.
    assign open_frame = (phase == PH_IDLE) && in_valid && in_start;
    assign take_bit   = (phase == PH_FILL) && in_valid;
    assign early_end  = take_bit && in_end && (cnt != k_q - 1'b1);
    assign last_bit   = open_frame ? (blk_size == KW'(1))
                                   : (take_bit && (cnt == k_q - 1'b1));
    assign buf_we     = open_frame || (take_bit && !early_end);
    assign buf_waddr  = open_frame ? '0 : cnt[AW-1:0];
    assign enc_step   = (phase == PH_ENC);
    assign enc_clear  = open_frame;

    frame_bit_store #(.DEPTH(MAX_K), .AW(AW)) i_store (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (in_bit),
        .raddr_a (cnt[AW-1:0]),
        .raddr_b (perm_idx[AW-1:0]),
        .rdata_a (rd_nat),
        .rdata_b (rd_perm)
    );

    qpp_index_gen #(.KW(KW)) i_perm (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (open_frame),
        .step  (enc_step),
        .k_in  (blk_size),
        .f1_in (coef_f1),
        .f2_in (coef_f2),
        .idx   (perm_idx)
    );

    assign enc_in = {rd_perm, rd_nat};

    // Two constituent encoders: index 0 natural order, 1 permuted order.
    for (genvar e = 0; e < NENC; e++) begin : g_enc
        rsc_encoder i_rsc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clear  (enc_clear),
            .step   (enc_step),
            .bit_in (enc_in[e]),
            .parity (enc_par[e]),
            .term_a (term_a[e]),
            .term_b (term_b[e])
        );
    end

    // Selects the termination word for the current tail cycle.
    always_comb begin
        case (cnt[1:0])
            2'd0:    tail_word = term_a[0];
            2'd1:    tail_word = term_b[0];
            2'd2:    tail_word = term_a[1];
            default: tail_word = term_b[1];
        endcase
    end

    // Phase sequencing and the shared position counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            k_q   <= '0;
        end else begin
            case (phase)
                PH_IDLE: if (open_frame) begin
                    k_q   <= blk_size;
                    phase <= last_bit ? PH_ENC : PH_FILL;
                    cnt   <= last_bit ? '0 : KW'(1);
                end
                PH_FILL: if (early_end) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else if (last_bit) begin
                    phase <= PH_ENC;
                    cnt   <= '0;
                end else if (take_bit) begin
                    cnt <= cnt + 1'b1;
                end
                PH_ENC: if (cnt == k_q - 1'b1) begin
                    phase <= PH_TAIL;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: if (cnt[1:0] == 2'd3) begin
                    phase <= PH_IDLE;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            endcase
        end
    end

    // Registers the output word and its frame flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word  <= '0;
            out_valid <= 1'b0;
            out_start <= 1'b0;
            out_end   <= 1'b0;
            out_tail1 <= 1'b0;
            out_tail2 <= 1'b0;
        end else begin
            out_valid <= (phase == PH_ENC) || (phase == PH_TAIL);
            out_start <= (phase == PH_ENC) && (cnt == '0);
            out_end   <= (phase == PH_TAIL) && (cnt[1:0] == 2'd3);
            out_tail1 <= (phase == PH_TAIL) && !cnt[1];
            out_tail2 <= (phase == PH_TAIL) && cnt[1];
            if (phase == PH_ENC)       out_word <= {rd_nat, enc_par[0], enc_par[1]};
            else if (phase == PH_TAIL) out_word <= tail_word;
            else                       out_word <= '0;
        end
    end

    assert_tail2_follows_tail1_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_tail2) |-> $past(out_tail1));
    assert_end_on_last_tail_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_end |-> (out_tail2 && $past(out_tail2)));
    assert_start_is_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_start |-> (out_valid && !out_tail1 && !out_tail2));
    assert_valid_burst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_end) |=> out_valid);
    assert_busy_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ENC || phase == PH_TAIL) |-> !buf_we);
    assert_abort_idles_R11: assert property (@(posedge clk) disable iff (!rst_n)
        early_end |=> (phase == PH_IDLE && !out_valid));
endmodule

// File: tb/test_turbo_frame_seq.sv
// Bench: sweeps block sizes, coefficient pairs and data patterns; the
// reference permutation uses the closed formula and the reference
// encoders step bit by bit.
module test_turbo_frame_seq;
    localparam int MAX_K = 512;
    localparam int KW    = $clog2(MAX_K + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_bit = 1'b0, in_start = 1'b0, in_end = 1'b0, in_valid = 1'b0;
    logic [KW-1:0] blk_size = '0, coef_f1 = '0, coef_f2 = '0;
    logic [2:0]    out_word;
    logic          out_start, out_end, out_valid, out_tail1, out_tail2;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    int mon_n    = 0;
    logic [6:0] rec [0:2047];
    int         rcy [0:2047];

    turbo_frame_seq #(.MAX_K(MAX_K)) i_turbo_frame_seq (
        .clk(clk), .rst_n(rst_n), .in_bit(in_bit), .in_start(in_start),
        .in_end(in_end), .in_valid(in_valid), .blk_size(blk_size),
        .coef_f1(coef_f1), .coef_f2(coef_f2), .out_word(out_word),
        .out_start(out_start), .out_end(out_end), .out_valid(out_valid),
        .out_tail1(out_tail1), .out_tail2(out_tail2)
    );

    always #10 clk = ~clk;

    initial forever begin
        @(posedge clk);
        cyc++;
    end

    // Monitor: records every valid output word away from the edge.
    initial forever begin
        @(negedge clk);
        if (rst_n && out_valid && mon_n < 2048) begin
            rec[mon_n] = {out_word, out_start, out_end, out_tail1, out_tail2};
            rcy[mon_n] = cyc;
            mon_n++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit pat_bit(input int pat, input int i);
        case (pat)
            0: return 1'b0;
            1: return 1'b1;
            2: return i[0];
            default: return ((i * 37 + 11) % 13) < 6;
        endcase
    endfunction

    // Drives one frame; with sync_end the first bit waits for out_end.
    task automatic send_frame(input int k, input int f1, input int f2, input int pat,
                              input bit gaps, input bit sync_end, output int last_cyc);
        last_cyc = 0;
        for (int i = 0; i < k; i++) begin
            if (gaps && (i % 5 == 3)) begin
                @(negedge clk);
                in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
            end
            if (i == 0 && sync_end) begin
                for (int w = 0; w < 3000; w++) begin
                    @(negedge clk);
                    if (out_end) break;
                end
            end else begin
                @(negedge clk);
            end
            blk_size = KW'(k); coef_f1 = KW'(f1); coef_f2 = KW'(f2);
            in_valid = 1'b1;
            in_bit   = pat_bit(pat, i);
            in_start = (i == 0);
            in_end   = (i == k - 1);
            if (i == k - 1) last_cyc = cyc;
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0; in_bit = 1'b0;
    endtask

    task automatic wait_words(input int n);
        for (int w = 0; w < 3000 && mon_n < n; w++) @(negedge clk);
    endtask

    // Builds the expected words and compares them with the recording.
    task automatic check_frame(input int base, input int k, input int f1, input int f2,
                               input int pat, input int last_cyc);
        bit c [0:MAX_K-1];
        logic [6:0] exp_w;
        int a1, b1, c1, a2, b2, c2, fb, z1, z2, pi;
        bit t1 [0:5];
        bit t2 [0:5];
        for (int i = 0; i < k; i++) c[i] = pat_bit(pat, i);
        wait_words(base + k + 4);
        check(mon_n >= base + k + 4, "R5 word count", mon_n - base, k + 4);
        check(rcy[base] - last_cyc == 2, "R8 latency", rcy[base] - last_cyc, 2);
        check(rcy[base + k + 3] - rcy[base] == k + 3, "R5 contiguous",
              rcy[base + k + 3] - rcy[base], k + 3);
        a1 = 0; b1 = 0; c1 = 0; a2 = 0; b2 = 0; c2 = 0;
        for (int i = 0; i < k; i++) begin
            pi = int'((longint'(f1) * i + longint'(f2) * i * i) % k);
            fb = c[i] ^ b1 ^ c1; z1 = fb ^ a1 ^ c1; c1 = b1; b1 = a1; a1 = fb;
            fb = c[pi] ^ b2 ^ c2; z2 = fb ^ a2 ^ c2; c2 = b2; b2 = a2; a2 = fb;
            exp_w = {c[i], z1[0], z2[0], (i == 0), 1'b0, 1'b0, 1'b0};
            check(rec[base + i] === exp_w, "R3 R4 data word", rec[base + i], exp_w);
        end
        for (int s = 0; s < 3; s++) begin
            t1[2*s] = (b1 ^ c1) != 0; t1[2*s+1] = (a1 ^ c1) != 0;
            c1 = b1; b1 = a1; a1 = 0;
            t2[2*s] = (b2 ^ c2) != 0; t2[2*s+1] = (a2 ^ c2) != 0;
            c2 = b2; b2 = a2; a2 = 0;
        end
        exp_w = {t1[0], t1[1], t1[2], 4'b0010};
        check(rec[base + k] === exp_w, "R6 R7 tail 1", rec[base + k], exp_w);
        exp_w = {t1[3], t1[4], t1[5], 4'b0010};
        check(rec[base + k + 1] === exp_w, "R6 R7 tail 2", rec[base + k + 1], exp_w);
        exp_w = {t2[0], t2[1], t2[2], 4'b0001};
        check(rec[base + k + 2] === exp_w, "R6 R7 tail 3", rec[base + k + 2], exp_w);
        exp_w = {t2[3], t2[4], t2[5], 4'b0101};
        check(rec[base + k + 3] === exp_w, "R5 R6 R7 tail 4", rec[base + k + 3], exp_w);
    endtask

    initial begin
        int lc, lc2;
        int ks [0:4]  = '{40, 48, 56, 64, 104};
        int f1s [0:4] = '{3, 7, 19, 7, 7};
        int f2s [0:4] = '{10, 12, 42, 16, 26};
        repeat (3) @(negedge clk);
        check(!out_valid && !out_start && !out_end && !out_tail1 && !out_tail2,
              "R1 in reset", out_valid, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!out_valid && !out_start && !out_end && !out_tail1 && !out_tail2,
              "R1 after reset", out_valid, 0);

        // R2 R3 R4: sweep of sizes, coefficients and patterns, some gapped.
        for (int s = 0; s < 5; s++) begin
            for (int p = 0; p < 4; p++) begin
                mon_n = 0;
                send_frame(ks[s], f1s[s], f2s[s], p, (p + s) % 2 == 1, 1'b0, lc);
                check_frame(0, ks[s], f1s[s], f2s[s], p, lc);
                repeat (10) @(negedge clk);
            end
        end

        // R9: input during encoding is ignored.
        mon_n = 0;
        send_frame(64, 7, 16, 3, 1'b0, 1'b0, lc);
        for (int j = 0; j < 12; j++) begin
            @(negedge clk);
            blk_size = KW'(40); coef_f1 = KW'(3); coef_f2 = KW'(10);
            in_valid = 1'b1; in_start = 1'b1; in_bit = j[0]; in_end = (j == 11);
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        check_frame(0, 64, 7, 16, 3, lc);
        repeat (150) @(negedge clk);
        check(mon_n == 68, "R9 no extra frame", mon_n, 68);

        // R10: next frame starts in the out_end cycle.
        mon_n = 0;
        send_frame(40, 3, 10, 3, 1'b0, 1'b0, lc);
        send_frame(48, 7, 12, 2, 1'b0, 1'b1, lc2);
        check_frame(0, 40, 3, 10, 3, lc);
        check_frame(44, 48, 7, 12, 2, lc2);
        check(rec[44][3] === 1'b1, "R10 second start", rec[44][3], 1);

        // R11: early end abandons the frame.
        repeat (10) @(negedge clk);
        mon_n = 0;
        send_frame(6, 0, 0, 1, 1'b0, 1'b0, lc);
        blk_size = KW'(40);
        // send_frame held blk_size=6; resend with K=40 ending after 6 bits
        repeat (60) @(negedge clk);
        mon_n = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            blk_size = KW'(40); coef_f1 = KW'(3); coef_f2 = KW'(10);
            in_valid = 1'b1; in_bit = 1'b1; in_start = (i == 0); in_end = (i == 5);
        end
        @(negedge clk);
        in_valid = 1'b0; in_start = 1'b0; in_end = 1'b0;
        repeat (120) @(negedge clk);
        check(mon_n == 0, "R11 no output after abort", mon_n, 0);
        send_frame(40, 3, 10, 2, 1'b1, 1'b0, lc);
        check_frame(0, 40, 3, 10, 2, lc);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule